// File: doc/BRIEF.md
# At-Speed Scan Clock Controller

This block produces the single internal clock that drives the scan flops of a logic region during at-speed scan test. Three inputs select the mode. In functional operation the free-running fast clock passes through unchanged. When test is enabled, scan shifting runs on the slow tester clock. When the tester drops the shift enable, the block emits a short burst of fast-clock pulses, a launch pulse followed by a capture pulse, so that delay defects are exercised at full speed while the tester only supplies a slow clock. A bypass control hands the output to the tester clock in every phase.

Each capture pattern chooses which fast pulses of its burst are released. That choice is made by a small clock-chain register, which sits on the scan path, shifts on the falling edge of the internal clock and holds its contents during capture. The shift enable comes from the slow domain. It is resynchronised into the fast domain before it can start a burst, and the burst opens a fixed number of fast cycles after the synchronised falling edge.

Changes of source go through a glitch-free mux with cross-coupled, falling-edge selects. The fast pulses pass through a gate whose enable is taken while the fast clock is low. As a result, the output never carries a truncated pulse.

Top module: `atspeed_clk_ctrl`

## Requirements
- R1: With tst_en=0 and byp_en=0, core_clk carries every fast_clk pulse, e.g. 32 rising edges in 160 ns at a 5 ns fast period.
- R2: With tst_en=1, byp_en=0 and shift_en=1, core_clk follows slow_clk, giving one rising edge per slow period.
- R3: With tst_en=1, byp_en=0 and shift_en=0, core_clk gives at most CHAIN_LEN fast pulses per capture window. Clock-chain bit 0 releases the first (launch) pulse and bit 1 the second (capture) pulse, so the pulse count equals the number of set chain bits. No slow pulse reaches the output in this phase.
- R4: With byp_en=1, core_clk follows slow_clk whatever tst_en and shift_en are, and fast_clk never reaches the output.
- R5: The clock chain shifts on the falling edge of core_clk while shift_en=1. chain_si enters bit 0, and bit CHAIN_LEN-1 drives chain_so. While shift_en=0 the chain holds its value.
- R6: shift_en passes through a fast-domain synchronizer of 2 stages (3 when SYNC_EXTRA=1) before a burst can start. The first burst pulse comes LAUNCH_DLY fast cycles after the synchronised fall, and no burst pulse appears within 24 ns of the shift_en fall at default settings.
- R7: core_clk never has a high or low phase shorter than half a fast period, and the fast and slow mux legs are never enabled together.
- R8: While rst=1 (synchronous, active high), core_clk stays low and the clock chain reads all zeros. Reset also returns the synchronizer to the shift value and the burst sequencer to idle, so a capture right after reset releases no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Free-running fast clock from the on-chip multiplier |
| slow_clk | input | 1 | Slow tester clock used for shifting and bypass |
| rst | input | 1 | Synchronous active-high reset |
| tst_en | input | 1 | 1 = scan test operation, 0 = functional |
| shift_en | input | 1 | 1 = shift phase, 0 = capture phase (slow domain) |
| byp_en | input | 1 | 1 = tester clock drives the output in every phase |
| chain_si | input | 1 | Serial input of the clock chain |
| chain_so | output | 1 | Serial output of the clock chain (last bit) |
| core_clk | output | 1 | Internal scan/functional clock |

## Verification
A wrong clock-chain bit or a stuck burst sequencer shows up as the wrong number of core_clk rising edges inside that same capture window. The pulses are due about seven fast cycles after shift_en falls, so the fault appears within one slow period. A synchronizer that is too short moves the launch pulse earlier, and the fault is visible as a pulse in the first 24 ns of capture. A select fault in the source mux shows as a narrow phase or as overlapping sources on core_clk within a few cycles of a mode change. A chain that fails to hold or to clear changes chain_so or the pulse count of the next capture.

// File: rtl/atclk_pkg.sv
package atclk_pkg;

  // Burst sequencer states (fast domain)
  typedef enum logic [1:0] {
    BST_IDLE = 2'd0,
    BST_WAIT = 2'd1,
    BST_FIRE = 2'd2,
    BST_DONE = 2'd3
  } burst_st_t;

  // Counter width able to hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/atclk_sync.sv
module atclk_sync #(
  parameter bit SYNC_EXTRA = 1'b0,
  parameter bit RST_VAL    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int DEPTH = SYNC_EXTRA ? 3 : 2;

  logic [DEPTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {DEPTH{RST_VAL}};
    else     stg <= {stg[DEPTH-2:0], d};
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/atclk_chain.sv
module atclk_chain #(
  parameter int LEN = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift,
  input  logic           si,
  output logic [LEN-1:0] bits
);
  // The clock of this register is held low while reset is active,
  // so the reset acts without waiting for an edge.
  generate
    if (LEN == 1) begin : g_single
      always_ff @(negedge clk or posedge rst) begin
        if (rst)        bits <= '0;
        else if (shift) bits <= si;
      end
    end else begin : g_multi
      always_ff @(negedge clk or posedge rst) begin
        if (rst)        bits <= '0;
        else if (shift) bits <= {bits[LEN-2:0], si};
      end
    end
  endgenerate
endmodule

// File: rtl/atclk_burst.sv
module atclk_burst
  import atclk_pkg::*;
#(
  parameter int LEN        = 2,
  parameter int LAUNCH_DLY = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cap_mode,
  input  logic           se_sync,
  input  logic [LEN-1:0] chain,
  output logic           gclk,
  output logic           gate_req,
  output logic           fire
);
  localparam int MAXC = (LEN > LAUNCH_DLY) ? LEN : LAUNCH_DLY;
  localparam int CW   = cnt_width(MAXC);

  burst_st_t st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic se_prev;
  logic gate_n;
  logic en_l;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (!cap_mode || se_sync) begin
      st_n  = BST_IDLE;
      cnt_n = '0;
    end else begin
      unique case (st)
        BST_IDLE: if (se_prev) begin
          st_n  = BST_WAIT;
          cnt_n = '0;
        end
        BST_WAIT: if (cnt == CW'(LAUNCH_DLY - 1)) begin
          st_n  = BST_FIRE;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
        BST_FIRE: if (cnt == CW'(LEN - 1)) begin
          st_n  = BST_DONE;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    gate_n = 1'b0;
    if (st_n == BST_FIRE) begin
      for (int i = 0; i < LEN; i++) begin
        if (cnt_n == CW'(i)) gate_n = chain[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= BST_IDLE;
      cnt      <= '0;
      se_prev  <= 1'b1;
      gate_req <= 1'b0;
      fire     <= 1'b0;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      se_prev  <= se_sync;
      gate_req <= gate_n;
      fire     <= (st_n == BST_FIRE);
    end
  end

  // Clock gate: enable taken only while the fast clock is low
  always_latch begin
    if (!clk) en_l = gate_req & ~rst;
  end

  assign gclk = clk & en_l;
endmodule

// File: rtl/atclk_gmux.sv
module atclk_gmux (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst,
  input  logic sel_a,
  output logic leg_a,
  output logic leg_b,
  output logic en_a,
  output logic en_b
);
  logic a_s1, b_s1;

  always_ff @(negedge clk_a) begin
    if (rst) begin
      a_s1 <= 1'b0;
      en_a <= 1'b0;
    end else begin
      a_s1 <= sel_a & ~en_b;
      en_a <= a_s1;
    end
  end

  always_ff @(negedge clk_b) begin
    if (rst) begin
      b_s1 <= 1'b0;
      en_b <= 1'b0;
    end else begin
      b_s1 <= ~sel_a & ~en_a;
      en_b <= b_s1;
    end
  end

  assign leg_a = clk_a & en_a;
  assign leg_b = clk_b & en_b;
endmodule

// File: rtl/atspeed_clk_ctrl.sv
module atspeed_clk_ctrl #(
  parameter int CHAIN_LEN  = 2,
  parameter int LAUNCH_DLY = 2,
  parameter bit SYNC_EXTRA = 1'b0
) (
  input  logic fast_clk,
  input  logic slow_clk,
  input  logic rst,
  input  logic tst_en,
  input  logic shift_en,
  input  logic byp_en,
  input  logic chain_si,
  output logic chain_so,
  output logic core_clk
);
  logic fast_req, cap_mode;
  logic se_sync, gate_req, burst_fire, burst_clk;
  logic en_fast, en_slow, leg_fast, leg_slow;
  logic [CHAIN_LEN-1:0] chain_q;

  assign fast_req = ~tst_en & ~byp_en;
  assign cap_mode =  tst_en & ~byp_en;

  atclk_gmux u_mux (
    .clk_a (fast_clk),
    .clk_b (slow_clk),
    .rst   (rst),
    .sel_a (fast_req),
    .leg_a (leg_fast),
    .leg_b (leg_slow),
    .en_a  (en_fast),
    .en_b  (en_slow)
  );

  atclk_sync #(.SYNC_EXTRA(SYNC_EXTRA), .RST_VAL(1'b1)) u_sync (
    .clk (fast_clk),
    .rst (rst),
    .d   (shift_en),
    .q   (se_sync)
  );

  atclk_burst #(.LEN(CHAIN_LEN), .LAUNCH_DLY(LAUNCH_DLY)) u_burst (
    .clk      (fast_clk),
    .rst      (rst),
    .cap_mode (cap_mode),
    .se_sync  (se_sync),
    .chain    (chain_q),
    .gclk     (burst_clk),
    .gate_req (gate_req),
    .fire     (burst_fire)
  );

  // Slow leg is silenced during capture; bursts only occur in capture
  assign core_clk = leg_fast | (leg_slow & (shift_en | ~cap_mode)) | burst_clk;

  atclk_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk   (core_clk),
    .rst   (rst),
    .shift (shift_en),
    .si    (chain_si),
    .bits  (chain_q)
  );

  assign chain_so = chain_q[CHAIN_LEN-1];
endmodule

// File: rtl/atclk_chk.sv
module atclk_chk #(
  parameter int LEN = 2
) (
  input logic           fast_clk,
  input logic           core_clk,
  input logic           rst,
  input logic           shift_en,
  input logic           cap_mode,
  input logic           se_sync,
  input logic           gate_req,
  input logic           burst_fire,
  input logic           en_fast,
  input logic           en_slow,
  input logic [LEN-1:0] chain_q
);
  logic [7:0] fire_cnt;

  always_ff @(posedge fast_clk) begin
    if (rst || se_sync)                        fire_cnt <= '0;
    else if (burst_fire && fire_cnt != 8'hFF) fire_cnt <= fire_cnt + 1'b1;
  end

  AST_BURST_LEN: assert property (@(posedge fast_clk) disable iff (rst)
    fire_cnt <= 8'(LEN)); // R3

  AST_GATE_IN_CAPTURE: assert property (@(posedge fast_clk) disable iff (rst)
    gate_req |-> (cap_mode && !se_sync)); // R3

  AST_FIRE_AFTER_SYNC: assert property (@(posedge fast_clk) disable iff (rst)
    $rose(burst_fire) |-> ($past(!se_sync) && $past(!shift_en, 2))); // R6

  AST_LEGS_EXCLUSIVE: assert property (@(posedge fast_clk) disable iff (rst)
    !(en_fast && en_slow)); // R7

  AST_CHAIN_HOLD: assert property (@(negedge core_clk) disable iff (rst)
    !shift_en |=> $stable(chain_q)); // R5
endmodule

bind atspeed_clk_ctrl atclk_chk #(.LEN(CHAIN_LEN)) u_chk (
  .fast_clk   (fast_clk),
  .core_clk   (core_clk),
  .rst        (rst),
  .shift_en   (shift_en),
  .cap_mode   (cap_mode),
  .se_sync    (se_sync),
  .gate_req   (gate_req),
  .burst_fire (burst_fire),
  .en_fast    (en_fast),
  .en_slow    (en_slow),
  .chain_q    (chain_q)
);

// File: tb/atspeed_clk_ctrl_tb.sv
`timescale 1ns/1ps
module atspeed_clk_ctrl_tb;
  logic fast_clk = 1'b0;
  logic slow_clk = 1'b0;
  logic rst      = 1'b1;
  logic tst_en   = 1'b1;
  logic shift_en = 1'b1;
  logic byp_en   = 1'b0;
  logic chain_si = 1'b0;
  logic chain_so;
  logic core_clk;

  atspeed_clk_ctrl u_dut (
    .fast_clk (fast_clk),
    .slow_clk (slow_clk),
    .rst      (rst),
    .tst_en   (tst_en),
    .shift_en (shift_en),
    .byp_en   (byp_en),
    .chain_si (chain_si),
    .chain_so (chain_so),
    .core_clk (core_clk)
  );

  always #2.5 fast_clk = ~fast_clk;  // 200 MHz
  always #20  slow_clk = ~slow_clk;  // 25 MHz tester clock

  int checks = 0;
  int fails  = 0;
  int edge_cnt = 0;
  int width_viol = 0;
  realtime last_t = 0.0;
  bit have_last = 1'b0;

  always @(posedge core_clk) edge_cnt++;

  // No phase of core_clk may be shorter than half a fast period (R7)
  always @(core_clk) begin
    if (have_last && (($realtime - last_t) < 2.4)) width_viol++;
    last_t    = $realtime;
    have_last = 1'b1;
  end

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic slot();
    @(negedge slow_clk);
    #1;
  endtask

  // {byp, tst, pat[1:0], so_chk, exp_shift[5:0], exp_cap[5:0]}
  localparam int NV = 8;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'b00, 1'b1, 6'd2,  6'd0},
    {1'b0, 1'b1, 2'b01, 1'b1, 6'd2,  6'd1},
    {1'b0, 1'b1, 2'b10, 1'b1, 6'd2,  6'd1},
    {1'b0, 1'b1, 2'b11, 1'b1, 6'd2,  6'd2},
    {1'b1, 1'b1, 2'b11, 1'b0, 6'd2,  6'd4},
    {1'b0, 1'b0, 2'b11, 1'b0, 6'd16, 6'd32},
    {1'b1, 1'b0, 2'b01, 1'b0, 6'd2,  6'd4},
    {1'b0, 1'b1, 2'b11, 1'b1, 6'd2,  6'd2}
  };

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog R1..R8 run actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int e0;
    // Reset state: output quiet, chain cleared (R8)
    #1;
    e0 = edge_cnt;
    repeat (6) slot();
    check_int("R8 no core_clk edges in reset", edge_cnt - e0, 0);
    check_int("R8 chain_so after reset", int'(chain_so), 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      logic [16:0] vv;
      logic [1:0]  pat;
      string tag_sh, tag_cp;
      vv  = VEC[v];
      pat = vv[14:13];
      if (vv[16])      begin tag_sh = "R4 bypass shift"; tag_cp = "R4 bypass capture"; end
      else if (vv[15]) begin tag_sh = "R2 shift";        tag_cp = "R3 capture burst";  end
      else             begin tag_sh = "R1 functional";   tag_cp = "R1 functional";     end

      byp_en   = vv[16];
      tst_en   = vv[15];
      shift_en = 1'b1;
      chain_si = 1'b0;
      repeat (4) slot();

      e0 = edge_cnt;
      chain_si = pat[1];
      slot();
      chain_si = pat[0];
      slot();
      check_int(tag_sh, edge_cnt - e0, int'(vv[11:6]));
      if (vv[12]) check_int("R5 chain_so after shift", int'(chain_so), int'(pat[1]));

      e0 = edge_cnt;
      shift_en = 1'b0;
      #24;
      if (vv[15] && !vv[16]) check_int("R6 no pulse before sync", edge_cnt - e0, 0);
      slot();
      repeat (3) slot();
      check_int(tag_cp, edge_cnt - e0, int'(vv[5:0]));
      if (vv[12]) check_int("R5 chain held in capture", int'(chain_so), int'(pat[1]));
      shift_en = 1'b1;
    end

    // Directed: reset in the middle of test operation (R8)
    slot();
    byp_en = 1'b0;
    tst_en = 1'b1;
    repeat (3) slot();
    chain_si = 1'b1;
    slot();
    slot();
    check_int("R5 chain_so loaded before reset", int'(chain_so), 1);
    rst = 1'b1;
    shift_en = 1'b0;
    chain_si = 1'b0;
    e0 = edge_cnt;
    repeat (6) slot();
    check_int("R8 core_clk low during reset", edge_cnt - e0, 0);
    check_int("R8 chain cleared by reset", int'(chain_so), 0);
    rst = 1'b0;
    e0 = edge_cnt;
    repeat (4) slot();
    check_int("R8 capture after reset releases nothing", edge_cnt - e0, 0);
    shift_en = 1'b1;
    repeat (2) slot();

    check_int("R7 narrow phases on core_clk", width_viol, 0);

    summary();
    $finish;
  end
endmodule